// File: doc/BRIEF.md
# Banked Per-Core Timer Address Decoder

This block sits between a shared register port and a bank of timer and watchdog register blocks, with one timer and one watchdog for each processor core. Every access carries the ID of the core that issued it. The decoder reads a window index from the address and steers the access to one register block. It forwards the low address bits to that block as a register offset, and one cycle later it returns either the block's read data or an error.

Two windows are relative to the requester. Window 0 reaches the requesting core's own timer, and window 1 reaches its own watchdog. The windows after those address each block directly. For core i, window 2+2i is the timer and window 3+2i is the watchdog. As a result, one physical block can be reached through two addresses.

The decoder also passes the blocks' interrupt lines straight out in slot order. It holds the clear line of every bank position active while reset is applied, including positions that the configured core count leaves unused.

Top module: `mptBankRouter`

## Requirements
- R1: A valid word access to window 0 selects slot 2*reqCore (that core's timer), and an access to window 1 selects slot 2*reqCore+1 (that core's watchdog).
- R2: A valid word access to window w, where 2 <= w < 2+2*NUM_CORES, selects slot w-2. Even slots are timers and odd slots are watchdogs.
- R3: Each window spans 32 bytes. The window index is reqAddr[ADDR_W-1:5], and reqAddr[4:0] appears unchanged on slotOffset during the request cycle.
- R4: Only word accesses are valid, meaning reqSize equal to 2 (0 is a byte, 1 is a halfword). Any other size selects no slot, performs no write and produces an error response.
- R5: An access through window 0 or window 1 with reqCore >= NUM_CORES selects no slot and produces an error response.
- R6: An access to a window index of 2+2*NUM_CORES or above selects no slot and produces an error response.
- R7: The cycle after each request, rspValid is high for exactly one cycle. On a read hit, rspRdata carries the selected slot's read data. On a write or an error, rspRdata is zero. rspErr is high only for erroring accesses.
- R8: At most one bit of slotSel is high at any time, and none is high while reqValid is low. slotWrite is high only together with a selected slot.
- R9: irqOut[k] follows slotIrq[k] in the same cycle. Bit 2i is core i's timer and bit 2i+1 is core i's watchdog.
- R10: While rstN is low, all 8 bits of slotClr are high, including bits beyond 2*NUM_CORES. After reset they are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address; bits above 4 select the window |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word |
| reqCore | input | 2 | ID of the requesting core |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspErr | output | 1 | Access was rejected |
| rspRdata | output | 32 | Read data, or zero |
| slotSel | output | 2*NUM_CORES | One-hot block select |
| slotWrite | output | 1 | Write strobe to the selected block |
| slotOffset | output | 5 | Register offset inside the block |
| slotWdata | output | 32 | Write data to the blocks |
| slotRdata | input | 64*NUM_CORES | Read data from each block, slot k at bits [32k+31:32k] |
| slotIrq | input | 2*NUM_CORES | Interrupt lines from the blocks |
| irqOut | output | 2*NUM_CORES | Interrupt lines, in slot order |
| slotClr | output | 8 | Clear for every bank position, including unused ones |

## Verification
The bench builds the block with NUM_CORES = 3 and ADDR_W = 12. With three cores, core ID 3 is a legal 2-bit value that is still out of range, so the alias error can be provoked. The windows from 8 upward are unmapped, and slot positions 6 and 7 exist only as clear lines, which exposes the reset coverage of unused slots. Each test writes through one window and reads the data back through the other view, which shows that the alias path and the absolute path land on the same block.

// File: rtl/mptRouterPkg.sv
package mptRouterPkg;
  localparam int MAX_CORES = 4;
  localparam int MAX_SLOTS = 2 * MAX_CORES;
  localparam int SLOT_W    = 3;
  localparam int DATA_W    = 32;
  localparam int OFFS_W    = 5;
  localparam logic [1:0] WORD_SIZE = 2'd2;

  // decode result handed from control to datapath
  typedef struct packed {
    logic              hit;
    logic              wr;
    logic              err;
    logic [SLOT_W-1:0] slot;
  } mptStrobe_t;
endpackage

// File: rtl/mptDecodeCtrl.sv
module mptDecodeCtrl
  import mptRouterPkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int WIN_W     = 7
) (
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [WIN_W-1:0] reqWin,
  input  logic [1:0]       reqSize,
  input  logic [1:0]       reqCore,
  output mptStrobe_t       strobe
);
  localparam int NUM_WIN = 2 + 2 * NUM_CORES;

  logic isAlias, inMap, sizeOk, coreOk, accessOk;

  always_comb begin
    isAlias  = reqWin < WIN_W'(2);
    inMap    = reqWin < WIN_W'(NUM_WIN);
    sizeOk   = reqSize == WORD_SIZE;
    coreOk   = {1'b0, reqCore} < 3'(NUM_CORES);
    accessOk = sizeOk && inMap && (!isAlias || coreOk);

    strobe.hit  = reqValid && accessOk;
    strobe.err  = reqValid && !accessOk;
    strobe.wr   = reqValid && accessOk && reqWrite;
    if (isAlias) strobe.slot = {reqCore, reqWin[0]};
    else         strobe.slot = SLOT_W'(reqWin - WIN_W'(2));
  end
endmodule

// File: rtl/mptRespPath.sv
module mptRespPath
  import mptRouterPkg::*;
#(
  parameter int SLOTS = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  mptStrobe_t              strobe,
  input  logic [OFFS_W-1:0]       reqOffset,
  input  logic [DATA_W-1:0]       reqWdata,
  input  logic [SLOTS*DATA_W-1:0] slotRdata,
  output logic [SLOTS-1:0]        slotSel,
  output logic                    slotWrite,
  output logic [OFFS_W-1:0]       slotOffset,
  output logic [DATA_W-1:0]       slotWdata,
  output logic                    rspValid,
  output logic                    rspErr,
  output logic [DATA_W-1:0]       rspRdata
);
  logic [DATA_W-1:0] rdMux;

  for (genvar g = 0; g < SLOTS; g++) begin : gSel
    assign slotSel[g] = strobe.hit && (strobe.slot == SLOT_W'(g));
  end

  assign slotWrite  = strobe.wr;
  assign slotOffset = reqOffset;
  assign slotWdata  = reqWdata;

  always_comb begin
    rdMux = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (slotSel[k]) rdMux = rdMux | slotRdata[k*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= strobe.hit || strobe.err;
      rspErr   <= strobe.err;
      rspRdata <= (strobe.hit && !strobe.wr) ? rdMux : '0;
    end
  end
endmodule

// File: rtl/mptBankRouter.sv
module mptBankRouter
  import mptRouterPkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic                        reqWrite,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [1:0]                  reqSize,
  input  logic [1:0]                  reqCore,
  input  logic [31:0]                 reqWdata,
  output logic                        rspValid,
  output logic                        rspErr,
  output logic [31:0]                 rspRdata,
  output logic [2*NUM_CORES-1:0]      slotSel,
  output logic                        slotWrite,
  output logic [4:0]                  slotOffset,
  output logic [31:0]                 slotWdata,
  input  logic [64*NUM_CORES-1:0]     slotRdata,
  input  logic [2*NUM_CORES-1:0]      slotIrq,
  output logic [2*NUM_CORES-1:0]      irqOut,
  output logic [7:0]                  slotClr
);
  localparam int SLOTS = 2 * NUM_CORES;
  localparam int WIN_W = ADDR_W - OFFS_W;

  mptStrobe_t strobe;

  mptDecodeCtrl #(.NUM_CORES(NUM_CORES), .WIN_W(WIN_W)) ctrl_i (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqWin   (reqAddr[ADDR_W-1:OFFS_W]),
    .reqSize  (reqSize),
    .reqCore  (reqCore),
    .strobe   (strobe)
  );

  mptRespPath #(.SLOTS(SLOTS)) path_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqOffset  (reqAddr[OFFS_W-1:0]),
    .reqWdata   (reqWdata),
    .slotRdata  (slotRdata),
    .slotSel    (slotSel),
    .slotWrite  (slotWrite),
    .slotOffset (slotOffset),
    .slotWdata  (slotWdata),
    .rspValid   (rspValid),
    .rspErr     (rspErr),
    .rspRdata   (rspRdata)
  );

  assign irqOut  = slotIrq;
  assign slotClr = {MAX_SLOTS{~rstN}};
endmodule

// File: rtl/mptBankRouterChk.sv
module mptBankRouterChk #(
  parameter int NUM_CORES = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   reqValid,
  input logic [1:0]             reqSize,
  input logic [2*NUM_CORES-1:0] slotSel,
  input logic                   slotWrite,
  input logic                   rspValid,
  input logic                   rspErr,
  input logic [31:0]            rspRdata
);
  // R8
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(slotSel));

  // R8
  idle_nosel_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> slotSel == '0);

  // R8
  write_has_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    slotWrite |-> $onehot(slotSel));

  // R7
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R7
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R4
  bad_size_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize != 2'd2) |=> (rspErr && rspRdata == '0));

  // R7
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspValid && rspRdata == '0));

  // R7
  hit_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotSel != '0) |=> !rspErr);
endmodule

bind mptBankRouter mptBankRouterChk #(.NUM_CORES(NUM_CORES)) chk_i (.*);

// File: tb/mptBankRouter_tb_top.sv
module mptBankRouter_tb_top;
  localparam int NC    = 3;
  localparam int SL    = 2 * NC;
  localparam int AW    = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0] reqSize = 2'd2, reqCore = 2'd0;
  logic [31:0] reqWdata = '0;
  logic rspValid, rspErr;
  logic [31:0] rspRdata;
  logic [SL-1:0] slotSel, irqOut;
  logic [SL-1:0] slotIrq = '0;
  logic slotWrite;
  logic [4:0] slotOffset;
  logic [31:0] slotWdata;
  logic [64*NC-1:0] slotRdata;
  logic [7:0] slotClr;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [31:0] stubMem [SL][8];
  logic [31:0] model   [SL][8];
  logic        errQ [$];
  logic [31:0] dataQ [$];
  string       tagQ [$];

  always #2.5 clk = ~clk;

  mptBankRouter #(.NUM_CORES(NC), .ADDR_W(AW)) dut_i (.*);

  // register block stubs
  always @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SL; s++)
        for (int k = 0; k < 8; k++) stubMem[s][k] <= 32'hC0DE_0000 | (s << 8) | k;
    end else if (slotWrite) begin
      for (int s = 0; s < SL; s++)
        if (slotSel[s]) stubMem[s][slotOffset[4:2]] <= slotWdata;
    end
  end

  always_comb begin
    for (int s = 0; s < SL; s++) slotRdata[s*32 +: 32] = stubMem[s][slotOffset[4:2]];
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // route computed from the requirement text
  task automatic access(input bit wr, input int win, input int off, input logic [1:0] sz,
                        input int core, input logic [31:0] wd, input string tag);
    bit err;
    int slot;
    logic [SL-1:0] expSel;
    logic [31:0] expData;
    slot = 0;
    err = (sz != 2'd2) || (win >= 2 + 2 * NC) || (win < 2 && core >= NC);
    if (!err) slot = (win < 2) ? (2 * core + win) : (win - 2);
    expSel  = err ? '0 : SL'(1 << slot);
    expData = (err || wr) ? 32'h0 : model[slot][off >> 2];
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = AW'(win * 32 + off);
    reqSize = sz; reqCore = 2'(core); reqWdata = wd;
    errQ.push_back(err); dataQ.push_back(expData); tagQ.push_back(tag);
    #1;
    chk(slotSel == expSel, tag, 64'(slotSel), 64'(expSel));
    if (!err) chk(slotOffset == 5'(off), {tag, " offset"}, 64'(slotOffset), 64'(off));
    chk(slotWrite == (wr && !err), {tag, " wstrobe"}, 64'(slotWrite), 64'(wr && !err));
    if (wr && !err) model[slot][off >> 2] = wd;
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    // R8 idle
    chk(slotSel == '0, "R8 idle select", 64'(slotSel), 0);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (errQ.size() == 0) chk(1'b0, "R7 unexpected response", 1, 0);
      else begin
        automatic logic  e = errQ.pop_front();
        automatic logic [31:0] d = dataQ.pop_front();
        automatic string t = tagQ.pop_front();
        chk(rspErr == e, {t, " rspErr"}, 64'(rspErr), 64'(e));
        chk(rspRdata == d, {t, " rspRdata"}, 64'(rspRdata), 64'(d));
      end
    end
  end

  initial begin
    for (int s = 0; s < SL; s++)
      for (int k = 0; k < 8; k++) model[s][k] = 32'hC0DE_0000 | (s << 8) | k;
    repeat (3) @(negedge clk);
    // R10: every clear line, unused positions included
    chk(slotClr == 8'hFF, "R10 clear in reset", 64'(slotClr), 64'hFF);
    chk(rspValid == 1'b0, "R7 reset response", 64'(rspValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(slotClr == 8'h00, "R10 clear released", 64'(slotClr), 0);

    // R2: absolute windows
    for (int w = 2; w < 2 + SL; w++) access(0, w, 4, 2'd2, 0, 0, "R2 absolute read");
    // R1: alias windows for each core
    for (int c = 0; c < NC; c++) begin
      access(0, 0, 0, 2'd2, c, 0, "R1 alias timer");
      access(0, 1, 12, 2'd2, c, 0, "R1 alias watchdog");
    end
    // R1 and R2: write through alias, read back through absolute
    access(1, 1, 8, 2'd2, 1, 32'h1234_5678, "R1 alias write");
    access(0, 5, 8, 2'd2, 0, 0, "R2 absolute readback");
    access(1, 6, 16, 2'd2, 0, 32'hDEAD_BEEF, "R2 absolute write");
    access(0, 0, 16, 2'd2, 2, 0, "R1 alias readback");
    // R3: highest offset in a window
    access(1, 2, 28, 2'd2, 0, 32'h0BAD_F00D, "R3 offset write");
    access(0, 0, 28, 2'd2, 0, 0, "R3 offset readback");
    // R4: narrow accesses rejected, contents untouched
    access(1, 3, 0, 2'd0, 0, 32'hFFFF_FFFF, "R4 byte write");
    access(1, 3, 0, 2'd1, 0, 32'hFFFF_FFFF, "R4 half write");
    access(0, 3, 0, 2'd1, 0, 0, "R4 half read");
    access(0, 3, 0, 2'd2, 0, 0, "R4 readback unchanged");
    // R5: alias with out-of-range core
    access(0, 0, 0, 2'd2, 3, 0, "R5 alias timer bad core");
    access(1, 1, 0, 2'd2, 3, 32'h5555_5555, "R5 alias wdog bad core");
    // R6: unmapped windows
    access(0, 2 + SL, 0, 2'd2, 0, 0, "R6 first unmapped");
    access(1, 100, 4, 2'd2, 0, 32'h7777_7777, "R6 far unmapped");
    access(0, 7, 4, 2'd2, 0, 0, "R6 last mapped intact");
    // R9: interrupt order
    slotIrq = 6'b100101;
    #1 chk(irqOut == 6'b100101, "R9 irq order", 64'(irqOut), 64'h25);
    slotIrq = 6'b011010;
    #1 chk(irqOut == 6'b011010, "R9 irq order swap", 64'(irqOut), 64'h1A);
    repeat (3) @(negedge clk);
    chk(errQ.size() == 0, "R7 responses outstanding", 64'(errQ.size()), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule